// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of ownership flags that two independent ports, called left and right, use to coordinate access to a shared resource. Each port has its own select, memory-enable, write-strobe, address and data inputs, and its own read-data output. A port claims a flag by writing a request to it. On a later cycle it reads the same flag to learn whether it now holds it. The owner writes a release when it is done.

When the other port already holds a flag, a request is remembered as pending. The flag passes to the waiting port at the same clock edge that the owner releases it. If both ports request the same free flag in the same cycle, exactly one of them wins. The winning side alternates from one tie to the next. Everything runs on a single clock. Strobes are single-cycle, and a read returns the state held before that cycle's edge.

Top module: `sem_bank`

## Requirements
- R1: The flag index is taken from the low three address bits (address[2:0]) of the accessing port. Higher address bits have no effect on which flag is touched.
- R2: A port makes a semaphore access only in a cycle where its select is 1 and its memory enable is 0. In any other cycle a write changes no flag, and the read data is all ones.
- R3: On a semaphore read (write strobe 0), every read-data bit carries one value: 0 when the reading port holds the addressed flag, and 1 otherwise. A free flag reads 1 from both ports.
- R4: A write with data bit 0 equal to 0 is a request. A request to a free flag grants it at that clock edge, and a read on the next cycle shows 0.
- R5: A write with data bit 0 equal to 1 is a release. A release from the owner frees the flag.
- R6: A release from the port that does not own the flag leaves ownership unchanged. It does withdraw any pending request from that port.
- R7: A request made while the other port owns the flag becomes pending. The flag is handed to the waiting port at the edge where the owner releases it.
- R8: When both ports request the same free flag in the same cycle, exactly one is granted and the other becomes pending. The first such tie after reset goes to left, and the winner alternates on every later tie.
- R9: No flag is ever owned by both ports at once.
- R10: Accesses by the two ports to different flags in the same cycle do not interact.
- R11: Reset makes every flag free, clears all pending requests, and gives the next tie to left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lft_sel | input | 1 | Left semaphore select |
| lft_mem_en | input | 1 | Left memory-array enable; blocks semaphore access when 1 |
| lft_we | input | 1 | Left write strobe (1 write, 0 read) |
| lft_addr | input | ADDR_W | Left address; low bits pick the flag |
| lft_wdata | input | DATA_W | Left write data; bit 0 is the request/release code |
| lft_rdata | output | DATA_W | Left read data |
| rgt_sel | input | 1 | Right semaphore select |
| rgt_mem_en | input | 1 | Right memory-array enable; blocks semaphore access when 1 |
| rgt_we | input | 1 | Right write strobe |
| rgt_addr | input | ADDR_W | Right address |
| rgt_wdata | input | DATA_W | Right write data |
| rgt_rdata | output | DATA_W | Right read data |

## Verification
The assertions are checked on every cycle. They cover mutual exclusion of ownership, uniform read-data bits, and the frozen flag state when neither port makes an access. They also check that an owner keeps a flag until it writes a release, and that the tie-break flips after each tie. Some behaviour can only be shown by the bench's scenarios, because it depends on a chain of accesses. This covers the hand-over to a pending requester, the alternating winner across separate ties, and the withdrawal of a pending request. It also covers the masking of high address bits, and the return to a left-first tie after reset.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_LFT  = 2'd1,
    OWN_RGT  = 2'd2
  } owner_e;

  // Read-back bit for one port: 0 when that port holds the flag, else 1.
  function automatic logic held_bit(owner_e o, logic is_rgt);
    logic mine;
    mine = is_rgt ? (o == OWN_RGT) : (o == OWN_LFT);
    return ~mine;
  endfunction

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               sel,
  input  logic               mem_en,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               rd,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec
);
  logic acc, wr;
  logic unused_bits;

  assign acc = sel & ~mem_en;
  assign wr  = acc & we;
  assign rd  = acc & ~we;
  assign idx = addr[IDX_W-1:0];
  assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
    assign req_vec[g] = wr & ~wdata[0] & (idx == IDX_W'(g));
    assign rel_vec[g] = wr &  wdata[0] & (idx == IDX_W'(g));
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_l,
  input  logic   rel_l,
  input  logic   req_r,
  input  logic   rel_r,
  input  logic   pick_r,
  output owner_e owner,
  output logic   tie
);
  owner_e own_q, own_d;
  logic   pl_q, pl_d, pr_q, pr_d;

  always_comb begin
    own_d = own_q;
    pl_d  = pl_q;
    pr_d  = pr_q;
    tie   = 1'b0;
    unique case (own_q)
      OWN_LFT: begin
        pl_d = 1'b0;
        if (rel_l) begin
          pr_d  = 1'b0;
          own_d = ((pr_q | req_r) & ~rel_r) ? OWN_RGT : OWN_NONE;
        end else if (req_r) begin
          pr_d = 1'b1;
        end else if (rel_r) begin
          pr_d = 1'b0;
        end
      end
      OWN_RGT: begin
        pr_d = 1'b0;
        if (rel_r) begin
          pl_d  = 1'b0;
          own_d = ((pl_q | req_l) & ~rel_l) ? OWN_LFT : OWN_NONE;
        end else if (req_l) begin
          pl_d = 1'b1;
        end else if (rel_l) begin
          pl_d = 1'b0;
        end
      end
      default: begin
        pl_d = 1'b0;
        pr_d = 1'b0;
        if (req_l & req_r) begin
          tie   = 1'b1;
          own_d = pick_r ? OWN_RGT : OWN_LFT;
          pl_d  = pick_r;
          pr_d  = ~pick_r;
        end else if (req_l) begin
          own_d = OWN_LFT;
        end else if (req_r) begin
          own_d = OWN_RGT;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= OWN_NONE;
      pl_q  <= 1'b0;
      pr_q  <= 1'b0;
    end else begin
      own_q <= own_d;
      pl_q  <= pl_d;
      pr_q  <= pr_d;
    end
  end

  assign owner = own_q;
endmodule

// File: rtl/sem_tiebreak.sv
module sem_tiebreak (
  input  logic clk,
  input  logic rst_n,
  input  logic any_tie,
  output logic pick_r
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pick_r <= 1'b0;
    else if (any_tie) pick_r <= ~pick_r;
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lft_sel,
  input  logic              lft_mem_en,
  input  logic              lft_we,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic [DATA_W-1:0] lft_wdata,
  output logic [DATA_W-1:0] lft_rdata,
  input  logic              rgt_sel,
  input  logic              rgt_mem_en,
  input  logic              rgt_we,
  input  logic [ADDR_W-1:0] rgt_addr,
  input  logic [DATA_W-1:0] rgt_wdata,
  output logic [DATA_W-1:0] rgt_rdata
);
  localparam int IDX_W = $clog2(NUM_SEM);

  logic               rd_l, rd_r;
  logic [IDX_W-1:0]   idx_l, idx_r;
  logic [NUM_SEM-1:0] req_l_vec, rel_l_vec, req_r_vec, rel_r_vec;
  logic [NUM_SEM-1:0] tie_vec, own_l_vec, own_r_vec;
  owner_e             owner_q [NUM_SEM];
  logic               tie_evt, pick_r;

  sem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_l (
    .sel(lft_sel), .mem_en(lft_mem_en), .we(lft_we), .addr(lft_addr),
    .wdata(lft_wdata), .rd(rd_l), .idx(idx_l), .req_vec(req_l_vec), .rel_vec(rel_l_vec)
  );

  sem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_r (
    .sel(rgt_sel), .mem_en(rgt_mem_en), .we(rgt_we), .addr(rgt_addr),
    .wdata(rgt_wdata), .rd(rd_r), .idx(idx_r), .req_vec(req_r_vec), .rel_vec(rel_r_vec)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .req_l(req_l_vec[g]), .rel_l(rel_l_vec[g]),
      .req_r(req_r_vec[g]), .rel_r(rel_r_vec[g]),
      .pick_r(pick_r), .owner(owner_q[g]), .tie(tie_vec[g])
    );
    assign own_l_vec[g] = (owner_q[g] == OWN_LFT);
    assign own_r_vec[g] = (owner_q[g] == OWN_RGT);
  end

  assign tie_evt = |tie_vec;

  sem_tiebreak u_tb (.clk(clk), .rst_n(rst_n), .any_tie(tie_evt), .pick_r(pick_r));

  assign lft_rdata = rd_l ? {DATA_W{held_bit(owner_q[idx_l], 1'b0)}} : '1;
  assign rgt_rdata = rd_r ? {DATA_W{held_bit(owner_q[idx_r], 1'b1)}} : '1;
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lft_sel,
  input logic               lft_mem_en,
  input logic               rgt_sel,
  input logic               rgt_mem_en,
  input logic [DATA_W-1:0]  lft_rdata,
  input logic [DATA_W-1:0]  rgt_rdata,
  input logic [NUM_SEM-1:0] own_l_vec,
  input logic [NUM_SEM-1:0] own_r_vec,
  input logic [NUM_SEM-1:0] rel_l_vec,
  input logic [NUM_SEM-1:0] rel_r_vec,
  input logic               tie_evt,
  input logic               pick_r
);
  // R9
  no_dual_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l_vec & own_r_vec) == '0);

  // R3
  lft_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_rdata == '0) || (lft_rdata == '1));

  // R3
  rgt_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgt_rdata == '0) || (rgt_rdata == '1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!lft_sel || lft_mem_en) && (!rgt_sel || rgt_mem_en)) |=>
      ($stable(own_l_vec) && $stable(own_r_vec)));

  // R5
  lft_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(own_l_vec & ~rel_l_vec) & ~own_l_vec) == '0));

  // R5
  rgt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(own_r_vec & ~rel_r_vec) & ~own_r_vec) == '0));

  // R8
  tie_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tie_evt |=> (pick_r != $past(pick_r)));
endmodule

bind sem_bank sem_bank_chk #(.DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lft_sel(lft_sel), .lft_mem_en(lft_mem_en),
  .rgt_sel(rgt_sel), .rgt_mem_en(rgt_mem_en),
  .lft_rdata(lft_rdata), .rgt_rdata(rgt_rdata),
  .own_l_vec(own_l_vec), .own_r_vec(own_r_vec),
  .rel_l_vec(rel_l_vec), .rel_r_vec(rel_r_vec),
  .tie_evt(tie_evt), .pick_r(pick_r)
);

// File: tb/sem_bank_tb.sv
`timescale 1ns/1ps
module sem_bank_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int NVEC   = 23;

  // {l_sel,l_we,l_a[2:0],l_d0, r_sel,r_we,r_a[2:0],r_d0, exp_l,exp_r}
  localparam logic [13:0] VEC [NVEC] = '{
    14'b10_000_0_10_000_0_11, // R3 free reads 1
    14'b11_000_0_00_000_0_11, // R4 left request
    14'b10_000_0_10_000_0_01, // R4 left holds
    14'b00_000_0_11_000_0_11, // R7 right pends
    14'b10_000_0_10_000_0_01, // R7 still left
    14'b11_000_1_00_000_0_11, // R5/R7 left release
    14'b10_000_0_10_000_0_10, // R7 handed to right
    14'b11_000_1_00_000_0_11, // R6 non-owner release
    14'b10_000_0_10_000_0_10, // R6 right keeps
    14'b00_000_0_11_000_1_11, // R5 right release
    14'b10_000_0_10_000_0_11, // R5 free again
    14'b11_011_0_11_011_0_11, // R8 first tie
    14'b10_011_0_10_011_0_01, // R8 left won
    14'b11_011_1_00_000_0_11, // R8 left release
    14'b10_011_0_10_011_0_10, // R8 loser granted
    14'b00_000_0_11_011_1_11, // R5 right release
    14'b11_101_0_11_101_0_11, // R8 second tie
    14'b10_101_0_10_101_0_10, // R8 right won
    14'b11_001_0_11_010_0_11, // R10 distinct flags
    14'b10_001_0_10_010_0_00, // R10 both hold
    14'b10_010_0_10_001_0_11, // R10 cross reads
    14'b00_000_0_11_101_1_11, // R7 right release flag5
    14'b10_101_0_10_101_0_01  // R7 left granted
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lft_sel = 0, lft_mem_en = 0, lft_we = 0;
  logic rgt_sel = 0, rgt_mem_en = 0, rgt_we = 0;
  logic [ADDR_W-1:0] lft_addr = '0, rgt_addr = '0;
  logic [DATA_W-1:0] lft_wdata = '0, rgt_wdata = '0;
  logic [DATA_W-1:0] lft_rdata, rgt_rdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lft_sel(lft_sel), .lft_mem_en(lft_mem_en), .lft_we(lft_we),
    .lft_addr(lft_addr), .lft_wdata(lft_wdata), .lft_rdata(lft_rdata),
    .rgt_sel(rgt_sel), .rgt_mem_en(rgt_mem_en), .rgt_we(rgt_we),
    .rgt_addr(rgt_addr), .rgt_wdata(rgt_wdata), .rgt_rdata(rgt_rdata)
  );

  task automatic drive(input logic ls, input logic lm, input logic lw,
                       input logic [ADDR_W-1:0] la, input logic ld,
                       input logic rs, input logic rm, input logic rw,
                       input logic [ADDR_W-1:0] ra, input logic rd);
    @(negedge clk);
    lft_sel = ls; lft_mem_en = lm; lft_we = lw; lft_addr = la; lft_wdata = {7'h55, ld};
    rgt_sel = rs; rgt_mem_en = rm; rgt_we = rw; rgt_addr = ra; rgt_wdata = {7'h2A, rd};
    #1;
  endtask

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    drive(0, 0, 0, '0, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R11: all flags free after reset
    for (int i = 0; i < 8; i++) begin
      drive(1, 0, 0, ADDR_W'(i), 0, 1, 0, 0, ADDR_W'(i), 0);
      check("R11 left", lft_rdata, '1);
      check("R11 right", rgt_rdata, '1);
    end

    for (int v = 0; v < NVEC; v++) begin
      logic [13:0] e;
      e = VEC[v];
      drive(e[13], 0, e[12], {13'd0, e[11:9]}, e[8],
            e[7], 0, e[6], {13'd0, e[5:3]}, e[2]);
      check($sformatf("R3/R4-R10 vec%0d left", v), lft_rdata, {DATA_W{e[1]}});
      check($sformatf("R3/R4-R10 vec%0d right", v), rgt_rdata, {DATA_W{e[0]}});
    end

    // R11: reset mid-use frees flags and gives next tie to left
    do_reset();
    drive(1, 0, 0, 16'd1, 0, 1, 0, 0, 16'd2, 0);
    check("R11 flag1 freed", lft_rdata, '1);
    check("R11 flag2 freed", rgt_rdata, '1);
    drive(1, 0, 1, 16'd4, 0, 1, 0, 1, 16'd4, 0);
    drive(1, 0, 0, 16'd4, 0, 1, 0, 0, 16'd4, 0);
    check("R11 tie left", lft_rdata, '0);
    check("R11 tie right loses", rgt_rdata, '1);

    // R2: memory enable blocks access
    drive(1, 1, 0, 16'd4, 0, 0, 0, 0, '0, 0);
    check("R2 blocked read", lft_rdata, '1);
    drive(1, 1, 1, 16'd6, 0, 0, 1, 1, 16'd6, 0);
    drive(1, 0, 0, 16'd6, 0, 1, 0, 0, 16'd6, 0);
    check("R2 blocked write left", lft_rdata, '1);
    check("R2 blocked write right", rgt_rdata, '1);

    // R1: high address bits ignored
    drive(1, 0, 1, 16'hA5F7, 0, 0, 0, 0, '0, 0);
    drive(1, 0, 0, 16'h0007, 0, 1, 0, 0, 16'h3C07, 0);
    check("R1 left holds 7", lft_rdata, '0);
    check("R1 right sees 7 taken", rgt_rdata, '1);

    // R6: non-owner release withdraws its pending request
    drive(0, 0, 0, '0, 0, 1, 0, 1, 16'd7, 0);
    drive(0, 0, 0, '0, 0, 1, 0, 1, 16'd7, 1);
    drive(1, 0, 1, 16'd7, 1, 0, 0, 0, '0, 0);
    drive(1, 0, 0, 16'd7, 0, 1, 0, 0, 16'd7, 0);
    check("R6 pending withdrawn right", rgt_rdata, '1);
    check("R6 flag free left", lft_rdata, '1);

    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule